// File: doc/BRIEF.md
# Fused Multiply-Subtract Array Unit

This block computes the product of two 4-bit unsigned operands and subtracts a 4-bit two's-complement operand from it, in one step. The result is a 9-bit two's-complement value, which covers every possible outcome from -7 up to 233. The arithmetic is built as an explicit structure. An AND array forms the sixteen partial products. A carry-save tree of full adders then reduces them. The negated subtrahend enters that same tree as one more addend row, and its "+1" goes into a free least-significant carry slot. A single ripple carry-propagate adder produces the final value. No separate subtractor stage follows the multiplier.

The arithmetic core is purely combinational. The top level places a register on the operands and a register on the result, so that the core's delay falls between two clock edges. A new operand set can therefore be presented on every cycle, and each result appears two edges later. Both registers clear on a synchronous active-low reset.

Top module: `fms_unit`

## Requirements
- R1: For every combination of operands, `f_o` equals X·Y − Z reduced modulo 2^9 and read as 9-bit two's complement.
- R2: X and Y are treated as unsigned, so X = 15 with Y = 15 and Z = 0 yields 225 (9'h0E1). This result is positive.
- R3: Z is treated as signed, with Z = 4'b1000 meaning −8. X = 15, Y = 15, Z = 4'b1000 yields 233 (9'h0E9), which is the largest result.
- R4: The smallest result is −7 (9'h1F9), produced when X·Y = 0 and Z = 7.
- R5: Read as a signed number, the result always lies in the range −7 to 233.
- R6: Operands present at rising edge n are reflected on `f_o` after rising edge n+1, for a latency of two registers.
- R7: A rising edge with `rst_n` low clears the pipeline. `f_o` reads 0 after that edge, whatever the operands are.
- R8: When X or Y is zero, the result is exactly −Z. This includes Z = −8, which gives +8.
- R9: A different operand set may be applied on every cycle. Each result appears in order, one per cycle, with no interference from its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the operand and result registers |
| rst_n | input | 1 | Synchronous active-low reset |
| x_i | input | 4 | Multiplicand, unsigned |
| y_i | input | 4 | Multiplier, unsigned |
| z_i | input | 4 | Subtrahend, two's complement |
| f_o | output | 9 | X·Y − Z, two's complement, registered |

## Verification
Two carries meet inside the reduction tree in the same cycle: the multiplier's partial-product carries and the "+1" that completes the negation of Z. The worst case for this is X = Y = 15 with Z = −8. In that case every partial product is 1, and the inverted Z row produces its own carry chain up through bit 3. Exhaustive streaming of all 4096 operand sets, one per cycle, lines every combination of these two carry sources up against a wider signed reference computed in the bench. A reset applied while results are still in flight checks that the clear takes priority over the data already in the pipeline.

// File: rtl/fms_pkg.sv
// Package: shared widths and types for the fused multiply-subtract unit.
// Assumes: the carry-save tree in fms_core is laid out for OPW operand bits,
// which gives OPW+1 addend rows plus one carry-in.
package fms_pkg;
    localparam int unsigned OPW   = 4;
    localparam int unsigned RESW  = 2 * OPW + 1;
    localparam int unsigned NROWS = OPW + 1;

    typedef logic [OPW-1:0]  opnd_t;
    typedef logic [RESW-1:0] res_t;

    // Behavioural reference, modulo 2^RESW; used only by assertions.
    function automatic res_t fms_ref(input opnd_t x, input opnd_t y, input opnd_t z);
        res_t xe, ye, ze;
        xe = res_t'(x);
        ye = res_t'(y);
        ze = {{(RESW-OPW){z[OPW-1]}}, z};
        return res_t'(xe * ye - ze);
    endfunction
endpackage

// File: rtl/fms_fa.sv
// Module: single-bit full adder.
// Assumes: nothing; pure combinational cell.
module fms_fa (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    // Sum and majority carry.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (a & ci) | (b & ci);
    end
endmodule

// File: rtl/fms_pp.sv
// Module: partial-product AND array. Row k holds (x AND y[k]) shifted left by k,
// zero-extended to W bits.
// Assumes: operands unsigned, W >= 2*N.
module fms_pp #(
    parameter int unsigned N = 4,
    parameter int unsigned W = 2 * N + 1
) (
    input  logic [N-1:0]        x,
    input  logic [N-1:0]        y,
    output logic [N-1:0][W-1:0] rows
);
    for (genvar k = 0; k < N; k++) begin : g_row
        logic [N-1:0] gated;
        // Gate the multiplicand by one multiplier bit.
        always_comb gated = x & {N{y[k]}};
        // Place the gated bits at weight 2^k.
        always_comb rows[k] = W'(gated) << k;
    end
endmodule

// File: rtl/fms_csa.sv
// Module: one carry-save row of W bit-slices. It compresses three vectors into
// a sum vector and a carry vector. The carry vector is shifted left by one
// position, and its free bit 0 takes lsb_in.
// Assumes: results wrap modulo 2^W; the carry out of the top slice is dropped.
module fms_csa #(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic         lsb_in,
    output logic [W-1:0] s,
    output logic [W-1:0] cy
);
    logic [W-1:0] co;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < W - 1) begin : g_fa
            fms_fa u_fa (.a(a[i]), .b(b[i]), .ci(c[i]), .s(s[i]), .co(co[i+1]));
        end else begin : g_top
            // Top slice: the carry would leave the word, so only the sum is formed.
            always_comb s[i] = a[i] ^ b[i] ^ c[i];
        end
    end

    // Shifted carries, with the injected bit at weight 1.
    always_comb co[0] = lsb_in;
    always_comb cy = co;

    // The row keeps the arithmetic value of its inputs.
    always_comb begin
        logic [W-1:0] lhs, rhs;
        lhs = s + cy;
        rhs = a + b + c + W'(lsb_in);
        assert_csa_conserve_R1: assert (lhs == rhs);
    end
endmodule

// File: rtl/fms_cpa.sv
// Module: W-bit ripple carry-propagate adder. This is the only carry chain in
// the datapath.
// Assumes: result wraps modulo 2^W.
module fms_cpa #(
    parameter int unsigned W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    logic [W-1:0] c;

    // No carry enters the bottom slice.
    always_comb c[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < W - 1) begin : g_fa
            fms_fa u_fa (.a(a[i]), .b(b[i]), .ci(c[i]), .s(s[i]), .co(c[i+1]));
        end else begin : g_top
            // Top slice: sum only, the carry out is discarded.
            always_comb s[i] = a[i] ^ b[i] ^ c[i];
        end
    end

    // The ripple result equals the word sum.
    always_comb begin
        logic [W-1:0] ref_sum;
        ref_sum = a + b;
        assert_cpa_sum_R1: assert (s == ref_sum);
    end
endmodule

// File: rtl/fms_core.sv
// Module: combinational X*Y - Z. The four partial-product rows and the inverted,
// sign-extended Z row are reduced by a three-level carry-save tree. The "+1" of
// the negation enters the free bit 0 of a first-level carry vector. One ripple
// adder finishes the sum.
// Assumes: fms_pkg::OPW == 4, which gives the fixed five-row tree below.
module fms_core
    import fms_pkg::*;
(
    input  opnd_t x,
    input  opnd_t y,
    input  opnd_t z,
    output res_t  f
);
    localparam int unsigned N = OPW;
    localparam int unsigned W = RESW;

    logic [N-1:0][W-1:0] pp;
    res_t zinv;
    res_t s1a, c1a, s1b, c1b, s2, c2, s3, c3;

    fms_pp #(.N(N), .W(W)) u_pp (.x(x), .y(y), .rows(pp));

    // Ones' complement of Z, sign-extended; +1 is added inside the tree.
    always_comb zinv = ~{{(W-N){z[N-1]}}, z};

    // Level 1: two rows in parallel; the second carries the negation's +1.
    fms_csa #(.W(W)) u_l1a (.a(pp[0]), .b(pp[1]), .c(pp[2]), .lsb_in(1'b0),
                            .s(s1a), .cy(c1a));
    fms_csa #(.W(W)) u_l1b (.a(pp[3]), .b(zinv), .c('0), .lsb_in(1'b1),
                            .s(s1b), .cy(c1b));
    // Level 2: four vectors down to three.
    fms_csa #(.W(W)) u_l2 (.a(s1a), .b(c1a), .c(s1b), .lsb_in(1'b0),
                           .s(s2), .cy(c2));
    // Level 3: three vectors down to two.
    fms_csa #(.W(W)) u_l3 (.a(s2), .b(c2), .c(c1b), .lsb_in(1'b0),
                           .s(s3), .cy(c3));
    // Final carry-propagate stage.
    fms_cpa #(.W(W)) u_cpa (.a(s3), .b(c3), .s(f));

    // The signed result stays inside the reachable range.
    always_comb begin
        assert_range_R5: assert ($signed(f) >= -7 && $signed(f) <= 233);
    end
endmodule

// File: rtl/fms_unit.sv
// Module: top level. Registers the operands, evaluates fms_core in one cycle,
// and registers the result.
// Assumes: synchronous active-low reset; a new operand set may arrive every cycle.
module fms_unit
    import fms_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OPW-1:0]      x_i,
    input  logic [OPW-1:0]      y_i,
    input  logic [OPW-1:0]      z_i,
    output logic [RESW-1:0]     f_o
);
    opnd_t xq, yq, zq;
    res_t  f_comb, f_q;
    logic [1:0] warm;

    // Capture the operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xq <= '0;
            yq <= '0;
            zq <= '0;
        end else begin
            xq <= x_i;
            yq <= y_i;
            zq <= z_i;
        end
    end

    fms_core u_core (.x(xq), .y(yq), .z(zq), .f(f_comb));

    // Capture the result.
    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_comb;
    end

    always_comb f_o = f_q;

    // Count non-reset edges so the latency check waits for a full pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) warm <= '0;
        else        warm <= {warm[0], 1'b1};
    end

    // Reset clears the result.
    assert_reset_zero_R7: assert property (@(posedge clk)
        !rst_n |=> (f_o == '0));

    // Result equals the reference of the operands two edges earlier.
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        warm[1] |-> (f_o == fms_ref($past(x_i, 2), $past(y_i, 2), $past(z_i, 2))));

    // With a zero factor the result is exactly the negated subtrahend.
    assert_neg_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm[1] && ($past(x_i, 2) == '0 || $past(y_i, 2) == '0)) |->
        (f_o == res_t'(-{{(RESW-OPW){$past(z_i[OPW-1], 2)}}, $past(z_i, 2)})));
endmodule

// File: tb/fms_unit_tb.sv
module fms_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] x_i = '0, y_i = '0, z_i = '0;
    logic [8:0] f_o;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fms_unit u_dut (.clk(clk), .rst_n(rst_n), .x_i(x_i), .y_i(y_i), .z_i(z_i), .f_o(f_o));

    function automatic int expect_val(input int x, input int y, input int z4);
        int zs;
        zs = (z4 >= 8) ? z4 - 16 : z4;
        return x * y - zs;
    endfunction

    task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Apply one set, wait for the two-edge latency, sample at a falling edge.
    task automatic apply_one(input string req, input int x, input int y, input int z, input int exp);
        @(negedge clk);
        x_i = 4'(x); y_i = 4'(y); z_i = 4'(z);
        @(negedge clk);
        @(negedge clk);
        chk(req, f_o, 9'(exp));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        x_i = 4'd15; y_i = 4'd15; z_i = 4'b1000;
        repeat (3) @(negedge clk);
        chk("R7 reset output", f_o, 9'h000);
        rst_n = 1'b1;
    endtask

    task automatic t_corners;
        apply_one("R2 unsigned max", 15, 15, 0, 225);
        apply_one("R3 signed min Z", 15, 15, 8, 233);
        apply_one("R4 min result", 0, 9, 7, -7);
        apply_one("R4 min result y zero", 13, 0, 7, -7);
        apply_one("R8 zero x, z=-8", 0, 15, 8, 8);
        apply_one("R8 zero y, z=-1", 6, 0, 15, 1);
        apply_one("R8 all zero", 0, 0, 0, 0);
        apply_one("R1 mixed", 7, 9, 5, 58);
        apply_one("R1 mixed neg z", 3, 11, 12, 37);
    endtask

    // Stream every combination, one per cycle (R9), checking value and range.
    task automatic t_stream;
        for (int i = 0; i < 4098; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                int k, e;
                k = i - 2;
                e = expect_val(k & 15, (k >> 4) & 15, (k >> 8) & 15);
                chk("R1/R9 stream", f_o, 9'(e));
                checks++;
                if ($signed(f_o) < -7 || $signed(f_o) > 233) begin
                    errors++;
                    $display("FAIL R5 range got %0d expected -7..233", $signed(f_o));
                end
            end
            if (i < 4096) begin
                x_i = 4'(i & 15);
                y_i = 4'((i >> 4) & 15);
                z_i = 4'((i >> 8) & 15);
            end
        end
    endtask

    // Reset while results are in flight: the clear wins.
    task automatic t_reset_mid;
        @(negedge clk);
        x_i = 4'd12; y_i = 4'd10; z_i = 4'd3;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7 reset mid-flight", f_o, 9'h000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 first after reset", f_o, 9'h000);
        apply_one("R6 latency after reset", 12, 10, 3, 117);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_corners();
        t_stream();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule